// File: doc/BRIEF.md
# Square-Root Issue Controller with Reservation Table

This block decides, cycle by cycle, whether a floating-point operation may enter a shared arithmetic pipeline. Only the timing and resource occupancy are handled; the datapath is not. Two classes of operation exist. The first is a short four-cycle operation. The second is a long double-precision square root, which holds the shared adder and rounder for most of its 112-cycle life. A square root is not fully blocking. Its unpack and exception-test stages are released after its first two cycles, so later work can overlap with the tail of an earlier root.

Each request is checked against a table of future reservations, kept per resource as a shift register. If any resource the new operation would need at some future offset is already reserved at that offset, the request is stalled. Otherwise the operation is accepted and its whole usage pattern is written into the table. A one-cycle completion pulse marks the final rounding cycle of every operation.

A single iteration sequencer is held by a square root from its issue cycle through its last adder cycle. As a result, two square roots cannot start closer together than 111 cycles.

Top module: `fpsq_issue_ctrl`

## Requirements
- R1: Bit positions of `busy_o`: bit 0 unpack, bit 1 exception test, bit 2 mantissa adder, bit 3 rounder, bit 4 root sequencer. An accepted square root (`req_op_i`=1) uses unpack in its issue cycle (cycle 1) and exception test in cycle 2. It uses adder and rounder together in cycles 3 to 110, the adder alone in cycle 111 and the rounder alone in cycle 112. `busy_o` shows every reservation for the current cycle, including one made by an operation accepted in that cycle.
- R2: A square root holds the root sequencer in cycles 1 to 111, which is 111 cycles.
- R3: An accepted short operation (`req_op_i`=0) uses unpack, exception test, adder and rounder in cycles 1, 2, 3 and 4 respectively. Its completion is in cycle 4.
- R4: `stall_o` is high exactly when `req_valid_i` is high and some resource the requested operation needs k cycles from now is already reserved k cycles from now.
- R5: A request is accepted only when `req_valid_i` is high and `stall_o` is low. With `req_valid_i` low, `req_op_i` has no effect and `stall_o` stays low.
- R6: `done_o` pulses for one cycle in cycle 112 of a square root (cycle 1 being the issue cycle), with `done_op_o`=1. For a short operation the pulse is in cycle 4, with `done_op_o`=0.
- R7: A square root requested in the cycle after another square root was issued stalls for 110 cycles and is accepted 111 cycles after the first.
- R8: A short operation may issue 109 cycles after a square root. A square root may issue 2 cycles after a short operation. Short operations may issue back to back with no stall.
- R9: Asserting `rst_ni` low clears all reservations. Afterwards `busy_o`, `stall_o` and `done_o` are low, and any request is accepted.
- R10: No resource is booked twice in one cycle, and at most one completion occurs per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Issue request present |
| req_op_i | input | 1 | Operation class: 1 square root, 0 short operation |
| stall_o | output | 1 | Request blocked this cycle by a structural conflict |
| busy_o | output | 5 | Per-resource reservation for the current cycle |
| done_o | output | 1 | Final rounding cycle of an operation |
| done_op_o | output | 1 | Class of the completing operation |

## Verification
The completion pulse of one operation can land in the same cycle as the acceptance of the next. For example, a square root requested while a previous root is in its final rounding cycle is accepted at that moment. A short operation placed 109 cycles after a root completes one cycle after the root does. The bench provokes both cases with held requests and with a long pseudo-random stream. A behavioural model judges them every cycle: it holds a list of in-flight operations with their ages, and from that list it derives the expected stall, per-resource busy flags and completion.

// File: rtl/fpsq_pkg.sv
package fpsq_pkg;
  localparam int NUM_RES   = 5;
  localparam int SHORT_LAT = 4;

  typedef enum logic [2:0] {
    RES_UNPACK = 3'd0,
    RES_EXC    = 3'd1,
    RES_ADD    = 3'd2,
    RES_RND    = 3'd3,
    RES_SEQ    = 3'd4
  } res_e;

  typedef enum logic {
    OP_SHORT = 1'b0,
    OP_SQRT  = 1'b1
  } op_e;

  // resource res used k cycles after issue (k = 0 is the issue cycle)
  function automatic logic uses_f(op_e op, int res, int k, int mid);
    logic u;
    u = 1'b0;
    if (op == OP_SQRT) begin
      case (res)
        int'(RES_UNPACK): u = (k == 0);
        int'(RES_EXC):    u = (k == 1);
        int'(RES_ADD):    u = (k >= 2) && (k <= mid + 2);
        int'(RES_RND):    u = ((k >= 2) && (k <= mid + 1)) || (k == mid + 3);
        int'(RES_SEQ):    u = (k <= mid + 2);
        default:          u = 1'b0;
      endcase
    end else begin
      u = (k == res) && (res < SHORT_LAT);
    end
    return u;
  endfunction

  function automatic int lat_f(op_e op, int mid);
    return (op == OP_SQRT) ? mid + 4 : SHORT_LAT;
  endfunction
endpackage

// File: rtl/fpsq_pattern.sv
module fpsq_pattern
  import fpsq_pkg::*;
#(
  parameter int MID   = 108,
  parameter int DEPTH = MID + 4
) (
  input  op_e                             op_i,
  output logic [NUM_RES-1:0][DEPTH-1:0]   need_o,
  output logic [1:0][DEPTH-1:0]           end_o
);
  always_comb begin
    for (int r = 0; r < NUM_RES; r++) begin
      for (int k = 0; k < DEPTH; k++) begin
        need_o[r][k] = uses_f(op_i, r, k, MID);
      end
    end
  end

  // completion slot, one lane per operation class
  generate
    for (genvar c = 0; c < 2; c++) begin : g_end
      always_comb begin
        for (int k = 0; k < DEPTH; k++) begin
          end_o[c][k] = (op_i == op_e'(c)) && (k == lat_f(op_e'(c), MID) - 1);
        end
      end
    end
  endgenerate
endmodule

// File: rtl/fpsq_lane.sv
module fpsq_lane #(
  parameter int DEPTH = 112
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DEPTH-1:0] need_i,
  input  logic             accept_i,
  output logic             clash_o,
  output logic             now_o
);
  logic [DEPTH-1:0] held_q;

  assign clash_o = |(held_q & need_i);
  assign now_o   = held_q[0] | (accept_i & need_i[0]);

  // slot k holds the reservation for k cycles ahead; offset 0 is consumed now
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) held_q <= '0;
    else         held_q <= {1'b0, held_q[DEPTH-1:1]}
                         | ({DEPTH{accept_i}} & {1'b0, need_i[DEPTH-1:1]});
  end

  // R1
  shift_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    held_q[1] |=> held_q[0]);
endmodule

// File: rtl/fpsq_issue_ctrl.sv
module fpsq_issue_ctrl
  import fpsq_pkg::*;
#(
  parameter int SQRT_MID = 108
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic               req_op_i,
  output logic               stall_o,
  output logic [NUM_RES-1:0] busy_o,
  output logic               done_o,
  output logic               done_op_o
);
  localparam int DEPTH = SQRT_MID + 4;

  op_e                           op;
  logic [NUM_RES-1:0][DEPTH-1:0] need;
  logic [1:0][DEPTH-1:0]         end_need;
  logic [NUM_RES-1:0]            clash;
  logic [1:0]                    end_clash;
  logic [1:0]                    end_now;
  logic                          conflict;
  logic                          accept;

  assign op = op_e'(req_op_i);

  fpsq_pattern #(.MID(SQRT_MID), .DEPTH(DEPTH)) u_pattern (
    .op_i   (op),
    .need_o (need),
    .end_o  (end_need)
  );

  generate
    for (genvar r = 0; r < NUM_RES; r++) begin : g_res
      fpsq_lane #(.DEPTH(DEPTH)) u_lane (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .need_i   (need[r]),
        .accept_i (accept),
        .clash_o  (clash[r]),
        .now_o    (busy_o[r])
      );
    end
    for (genvar c = 0; c < 2; c++) begin : g_end
      fpsq_lane #(.DEPTH(DEPTH)) u_end (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .need_i   (end_need[c]),
        .accept_i (accept),
        .clash_o  (end_clash[c]),
        .now_o    (end_now[c])
      );
    end
  endgenerate

  assign conflict  = |clash;
  assign stall_o   = req_valid_i & conflict;
  assign accept    = req_valid_i & ~conflict;
  assign done_o    = |end_now;
  assign done_op_o = end_now[OP_SQRT];

  // R1
  sqrt_front_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && op == OP_SQRT) |=> (busy_o[RES_EXC] && busy_o[RES_SEQ]));

  // R2
  seq_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o[RES_SEQ]) |-> (done_o && done_op_o));

  // R6
  done_round_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o[RES_RND]);

  // R10
  single_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(end_now[0] && end_now[1]));

  // R10
  end_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|end_clash) |-> clash[RES_RND]);
endmodule

// File: tb/fpsq_issue_ctrl_tb_top.sv
`timescale 1ns/1ps
module fpsq_issue_ctrl_tb_top;
  localparam int MID  = 108;
  localparam int SLAT = MID + 4;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_op = 1'b0;
  logic       stall;
  logic [4:0] busy;
  logic       done, done_op;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int iss_t[$];
  bit iss_op[$];
  bit s_stall, s_done, s_dop;
  logic [4:0] s_busy;
  bit e_acc;

  always #2.5 clk = ~clk;

  fpsq_issue_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_op_i(req_op),
    .stall_o(stall), .busy_o(busy), .done_o(done), .done_op_o(done_op)
  );

  // occupancy per the requirements: sqrt spans [lo,hi] per resource
  function automatic bit use_m(bit op, int r, int k);
    if (k < 0) return 0;
    if (!op) return (k == r) && (r < 4);
    if (r == 4) return k < SLAT - 1;
    if (r == 2) return k >= 2 && k <= SLAT - 2;
    if (r == 3) return (k >= 2 && k <= SLAT - 3) || k == SLAT - 1;
    return k == r;
  endfunction

  function automatic int lat_m(bit op);
    return op ? SLAT : 4;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic step(bit v, bit op);
    bit conf;
    logic [4:0] eb;
    bit ed, edo;
    req_valid = v;
    req_op = op;
    #1;
    conf = 0; eb = '0; ed = 0; edo = 0;
    foreach (iss_t[q]) begin
      int age;
      age = cyc - iss_t[q];
      for (int r = 0; r < 5; r++) if (use_m(iss_op[q], r, age)) eb[r] = 1;
      if (age == lat_m(iss_op[q]) - 1) begin ed = 1; edo = iss_op[q]; end
      if (v) for (int k = 0; age + k < SLAT; k++)
        for (int r = 0; r < 5; r++)
          if (use_m(iss_op[q], r, age + k) && use_m(op, r, k)) conf = 1;
    end
    e_acc = v && !conf;
    if (e_acc) for (int r = 0; r < 5; r++) if (use_m(op, r, 0)) eb[r] = 1;
    s_stall = stall; s_busy = busy; s_done = done; s_dop = done_op;
    chk(stall === (v && conf), "R4 stall", int'(stall), int'(v && conf));
    chk(busy === eb, "R1 busy", int'(busy), int'(eb));
    chk(done === ed, "R6 done", int'(done), int'(ed));
    if (ed) chk(done_op === edo, "R6 done_op", int'(done_op), int'(edo));
    @(posedge clk);
    if (e_acc) begin iss_t.push_back(cyc); iss_op.push_back(op); end
    cyc++;
    while (iss_t.size() > 0 && cyc - iss_t[0] > SLAT) begin
      void'(iss_t.pop_front()); void'(iss_op.pop_front());
    end
    #1;
  endtask

  task automatic drain(int n);
    for (int i = 0; i < n; i++) step(0, 0);
  endtask

  task automatic do_reset();
    req_valid = 0;
    rst_ni = 0;
    iss_t.delete(); iss_op.delete();
    #1;
    chk(busy === 5'b0 && stall === 1'b0 && done === 1'b0, "R9 reset", int'(busy), 0);
    @(posedge clk); #1;
    rst_ni = 1;
    @(posedge clk); cyc++; #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=%0d exp=%0d", cyc, 0);
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int n, seq_n, done_at, dn;
    logic [15:0] lfsr;
    #1;
    do_reset();

    // lone sqrt: R1 R2 R6
    step(1, 1);
    seq_n = int'(s_busy[4]); done_at = -1; dn = 0;
    for (int i = 1; i < 116; i++) begin
      step(0, 0);
      seq_n += int'(s_busy[4]);
      if (s_done) begin done_at = i; dn++; end
    end
    chk(seq_n == 111, "R2 sequencer cycles", seq_n, 111);
    chk(done_at == 111, "R6 latency age", done_at, 111);
    chk(dn == 1, "R6 single pulse", dn, 1);

    // R7: back-to-back sqrt request
    step(1, 1);
    n = 0;
    forever begin step(1, 1); if (s_stall) n++; else break; end
    chk(n == 110, "R7 stall cycles", n, 110);
    drain(120);

    // R8: short after sqrt
    step(1, 1);
    n = 0;
    forever begin step(1, 0); if (s_stall) n++; else break; end
    chk(n == 108, "R8 short after sqrt stalls", n, 108);
    drain(120);

    // R8 R3: sqrt after short, then short stream
    step(1, 0);
    n = 0;
    forever begin step(1, 1); if (s_stall) n++; else break; end
    chk(n == 1, "R8 sqrt after short stalls", n, 1);
    drain(120);
    n = 0;
    for (int i = 0; i < 6; i++) begin step(1, 0); n += int'(s_stall); end
    chk(n == 0, "R8 short back to back", n, 0);
    done_at = -1;
    for (int i = 0; i < 4; i++) begin step(0, 0); if (s_done && done_at < 0) done_at = i; end
    chk(done_at == 0, "R3 short done in cycle 4", done_at, 0);
    drain(8);

    // R5: valid low ignored
    step(1, 1);
    n = 0;
    for (int i = 0; i < 20; i++) begin step(0, i[0]); n += int'(s_stall); end
    chk(n == 0, "R5 no stall when idle", n, 0);
    drain(100);
    chk(s_busy === 5'b0, "R5 no stray booking", int'(s_busy), 0);

    // R9: reset mid-flight
    step(1, 1);
    drain(30);
    do_reset();
    step(1, 1);
    chk(s_stall == 0, "R9 accept after reset", int'(s_stall), 0);

    // R10: mixed stream, model compares every cycle
    lfsr = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] | lfsr[3], lfsr[5] & lfsr[7] & lfsr[2]);
    end
    drain(120);

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule